// File: doc/BRIEF.md
# Packed Coefficient Transpose Buffer

This block sits between the column pass and the row pass of a two-dimensional inverse transform for square blocks of 4x4, 8x8, 16x16 and 32x32 coefficients. The column pass delivers each finished column as 128-bit words of eight 16-bit coefficients. The row pass later fetches the same block row by row, also eight coefficients per word. The buffer performs the transpose, so that data written in column order are read back in row order for every supported block size.

Storage holds a full 32x32 block of 16-bit values. It is built as eight independent 16-bit banks. The bank index is skewed by the sum of row and column. As a result, the eight coefficients of a column segment land in eight different banks, and so do the eight coefficients of a row segment. One full write and one full read can therefore be accepted in every cycle, with no stall. Read data are registered. Lanes that fall outside the selected block read as zero, and writes that fall outside it are dropped.

Top module: `tpb_top`

## Requirements
- R1: After reset, and until the first read request, `rd_data` is all zero.
- R2: `size_sel` selects the block dimension N: 0 for 4, 1 for 8, 2 for 16, 3 for 32. When `wr_en` is high, lane k (bits 16k+15:16k) of `wr_data` is stored as the element at row `wr_seg`*8+k, column `wr_col`. When `wr_en` is low, nothing is stored.
- R3: A read request (`rd_en` high) with row r and segment s makes lane k of `rd_data` equal to the element at row r, column s*8+k. The value appears after the next rising clock edge.
- R4: A write and a read may be requested in the same cycle. If they hit the same element, the read returns the contents from before that write. A later read returns the new value.
- R5: While `rd_en` is low, `rd_data` holds its last value.
- R6: When N is 4, lanes 4 to 7 of `wr_data` are ignored. Lanes 4 to 7 of every read result are zero.
- R7: A write lane whose row or column is N or larger is dropped. A read lane whose row or column is N or larger returns zero.
- R8: A write of eight in-range rows updates all eight banks in that cycle. It may be accompanied in the same cycle by a read, and each completes in a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| size_sel | input | 2 | Block dimension code (4, 8, 16 or 32) |
| wr_en | input | 1 | Store the column segment this cycle |
| wr_col | input | 5 | Column being written |
| wr_seg | input | 2 | Group of eight rows within the column |
| wr_data | input | 128 | Eight packed 16-bit coefficients, lane k is row seg*8+k |
| rd_en | input | 1 | Fetch a row segment this cycle |
| rd_row | input | 5 | Row being read |
| rd_seg | input | 2 | Group of eight columns within the row |
| rd_data | output | 128 | Registered row segment, lane k is column seg*8+k |

## Verification
The hardest case to create from the ports is a read and a write that reach the same bank location in the same cycle. With the skewed layout this happens only when the read row and the written column meet at one element. The stimulus forces this on purpose: it writes a column segment while reading a row that crosses it, and then reads that row again. The bench also runs a long random mix of concurrent writes and reads at all four sizes, with out-of-range indices, after the array has been filled at full size. This stresses the bank-rotation arithmetic against a plain two-dimensional array model.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  localparam int unsigned COEF_W   = 16;
  localparam int unsigned NUM_LANE = 8;
  localparam int unsigned MAX_DIM  = 32;

  // Block dimension selected by the 2-bit size code: 4, 8, 16, 32.
  function automatic int blk_dim(input logic [1:0] sel);
    return 4 << sel;
  endfunction

  // Bank that holds element (row, col): skew by row + col.
  function automatic int bank_of(input int row, input int col, input int lanes);
    return (row + col) % lanes;
  endfunction

  // Word slot inside a bank for element (row, col).
  function automatic int slot_of(input int row, input int col, input int lanes,
                                 input int max_n);
    return row * (max_n / lanes) + col / lanes;
  endfunction

endpackage

// File: rtl/tpb_bank.sv
module tpb_bank #(
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] q
);

  logic [CW-1:0] mem [DEPTH];

  // Read samples the array before this edge's write lands: old data.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/tpb_wr_route.sv
module tpb_wr_route #(
  parameter int unsigned CW    = 16,
  parameter int unsigned LANES = 8,
  parameter int unsigned MAX_N = 32,
  localparam int unsigned DW    = CW * LANES,
  localparam int unsigned IDX_W = $clog2(MAX_N),
  localparam int unsigned SEG_W = $clog2(MAX_N / LANES),
  localparam int unsigned BK_W  = $clog2(LANES),
  localparam int unsigned AW    = $clog2(MAX_N * MAX_N / LANES)
) (
  input  logic [1:0]                   size_sel,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             col,
  input  logic [SEG_W-1:0]             seg,
  input  logic [DW-1:0]                data,
  output logic [LANES-1:0]             bank_we,
  output logic [LANES-1:0][AW-1:0]     bank_addr,
  output logic [LANES-1:0][CW-1:0]     bank_wd
);

  logic [IDX_W:0] dim;
  assign dim = (IDX_W+1)'(tpb_pkg::blk_dim(size_sel));

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [BK_W-1:0]  lane;
    logic [IDX_W-1:0] row;
    // Lane k of a column word goes to bank (k + col) mod LANES.
    assign lane = BK_W'(b) - col[BK_W-1:0];
    assign row  = {seg, lane};
    assign bank_we[b]   = wr_en && ({1'b0, row} < dim) && ({1'b0, col} < dim);
    assign bank_addr[b] = AW'(tpb_pkg::slot_of(int'(row), int'(col), LANES, MAX_N));
    assign bank_wd[b]   = data[int'(lane)*CW +: CW];
  end

endmodule

// File: rtl/tpb_rd_route.sv
module tpb_rd_route #(
  parameter int unsigned LANES = 8,
  parameter int unsigned MAX_N = 32,
  localparam int unsigned IDX_W = $clog2(MAX_N),
  localparam int unsigned SEG_W = $clog2(MAX_N / LANES),
  localparam int unsigned BK_W  = $clog2(LANES),
  localparam int unsigned AW    = $clog2(MAX_N * MAX_N / LANES)
) (
  input  logic [1:0]       size_sel,
  input  logic [IDX_W-1:0] row,
  input  logic [SEG_W-1:0] seg,
  output logic [AW-1:0]    addr,
  output logic [BK_W-1:0]  rot,
  output logic [LANES-1:0] lane_ok
);

  logic [IDX_W:0] dim;
  assign dim  = (IDX_W+1)'(tpb_pkg::blk_dim(size_sel));
  // Every lane of a row segment shares one slot, in a different bank.
  assign addr = AW'(tpb_pkg::slot_of(int'(row), int'(seg) * LANES, LANES, MAX_N));
  assign rot  = row[BK_W-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_ok
    logic [IDX_W-1:0] col;
    assign col        = {seg, BK_W'(k)};
    assign lane_ok[k] = ({1'b0, row} < dim) && ({1'b0, col} < dim);
  end

endmodule

// File: rtl/tpb_rd_align.sv
module tpb_rd_align #(
  parameter int unsigned CW    = 16,
  parameter int unsigned LANES = 8,
  localparam int unsigned DW   = CW * LANES,
  localparam int unsigned BK_W = $clog2(LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     re,
  input  logic [BK_W-1:0]          rot_in,
  input  logic [LANES-1:0]         ok_in,
  input  logic [LANES-1:0][CW-1:0] bank_q,
  output logic [DW-1:0]            rd_data
);

  logic [BK_W-1:0]  rot_q;
  logic [LANES-1:0] ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q <= '0;
      ok_q  <= '0;
    end else if (re) begin
      rot_q <= rot_in;
      ok_q  <= ok_in;
    end
  end

  // Undo the skew: lane k of the row came from bank (row + k) mod LANES.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      rd_data[k*CW +: CW] = ok_q[k]
        ? bank_q[tpb_pkg::bank_of(int'(rot_q), k, LANES)] : '0;
    end
  end

endmodule

// File: rtl/tpb_top.sv
module tpb_top #(
  parameter int unsigned CW    = tpb_pkg::COEF_W,
  parameter int unsigned LANES = tpb_pkg::NUM_LANE,
  parameter int unsigned MAX_N = tpb_pkg::MAX_DIM,
  localparam int unsigned DW    = CW * LANES,
  localparam int unsigned IDX_W = $clog2(MAX_N),
  localparam int unsigned SEG_W = $clog2(MAX_N / LANES),
  localparam int unsigned BK_W  = $clog2(LANES),
  localparam int unsigned DEPTH = MAX_N * MAX_N / LANES,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size_sel,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_col,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_row,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [DW-1:0]    rd_data
);

  logic [LANES-1:0]         bank_we;
  logic [LANES-1:0][AW-1:0] bank_waddr;
  logic [LANES-1:0][CW-1:0] bank_wd;
  logic [LANES-1:0][CW-1:0] bank_q;
  logic [AW-1:0]            rd_addr;
  logic [BK_W-1:0]          rd_rot;
  logic [LANES-1:0]         rd_lane_ok;

  tpb_wr_route #(.CW(CW), .LANES(LANES), .MAX_N(MAX_N)) u_wr (
    .size_sel (size_sel),
    .wr_en    (wr_en),
    .col      (wr_col),
    .seg      (wr_seg),
    .data     (wr_data),
    .bank_we  (bank_we),
    .bank_addr(bank_waddr),
    .bank_wd  (bank_wd)
  );

  tpb_rd_route #(.LANES(LANES), .MAX_N(MAX_N)) u_rd (
    .size_sel(size_sel),
    .row     (rd_row),
    .seg     (rd_seg),
    .addr    (rd_addr),
    .rot     (rd_rot),
    .lane_ok (rd_lane_ok)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_mem
    tpb_bank #(.CW(CW), .DEPTH(DEPTH)) u_bank (
      .clk  (clk),
      .we   (bank_we[b]),
      .waddr(bank_waddr[b]),
      .wdata(bank_wd[b]),
      .re   (rd_en),
      .raddr(rd_addr),
      .q    (bank_q[b])
    );
  end

  tpb_rd_align #(.CW(CW), .LANES(LANES)) u_align (
    .clk    (clk),
    .rst_n  (rst_n),
    .re     (rd_en),
    .rot_in (rd_rot),
    .ok_in  (rd_lane_ok),
    .bank_q (bank_q),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/tpb_checker.sv
module tpb_checker #(
  parameter int unsigned CW    = 16,
  parameter int unsigned LANES = 8,
  parameter int unsigned MAX_N = 32,
  localparam int unsigned DW    = CW * LANES,
  localparam int unsigned IDX_W = $clog2(MAX_N),
  localparam int unsigned SEG_W = $clog2(MAX_N / LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       size_sel,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_col,
  input logic [SEG_W-1:0] wr_seg,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_row,
  input logic [SEG_W-1:0] rd_seg,
  input logic [DW-1:0]    rd_data,
  input logic [LANES-1:0] bank_we
);

  logic [IDX_W:0] dim;
  assign dim = (IDX_W+1)'(4) << size_sel;

  // R8: a full-size column write reaches every bank at once.
  p_full_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size_sel == 2'd3) |-> $countones(bank_we) == LANES);

  // R2: no bank is written without a write request.
  p_idle_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> bank_we == '0);

  // R7: a column outside the block touches nothing.
  p_col_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && {1'b0, wr_col} >= dim) |-> bank_we == '0);

  // R7: a row outside the block reads back as zero.
  p_row_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && {1'b0, rd_row} >= dim) |=> rd_data == '0);

  // R6: smallest block leaves the upper lanes at zero.
  p_small_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && size_sel == 2'd0) |=> rd_data[DW-1:4*CW] == '0);

  // R5: output holds while no read is requested.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind tpb_top tpb_checker #(.CW(CW), .LANES(LANES), .MAX_N(MAX_N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .size_sel(size_sel),
  .wr_en   (wr_en),
  .wr_col  (wr_col),
  .wr_seg  (wr_seg),
  .rd_en   (rd_en),
  .rd_row  (rd_row),
  .rd_seg  (rd_seg),
  .rd_data (rd_data),
  .bank_we (bank_we)
);

// File: tb/tpb_top_bench.sv
module tpb_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   size_sel = '0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_col = '0;
  logic [1:0]   wr_seg = '0;
  logic [127:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [4:0]   rd_row = '0;
  logic [1:0]   rd_seg = '0;
  logic [127:0] rd_data;

  int n_checks = 0;
  int n_errors = 0;
  string tag = "R1";
  logic [127:0] expect_q = '0;
  logic [15:0]  model [32][32];

  always #(CLK_PERIOD/2) clk = ~clk;

  tpb_top u_tpb_top (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel),
    .wr_en(wr_en), .wr_col(wr_col), .wr_seg(wr_seg), .wr_data(wr_data),
    .rd_en(rd_en), .rd_row(rd_row), .rd_seg(rd_seg), .rd_data(rd_data)
  );

  function automatic int dim_of(input logic [1:0] s);
    case (s)
      2'd0: return 4;
      2'd1: return 8;
      2'd2: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [127:0] model_row(input logic [1:0] s, input int r, input int sg);
    logic [127:0] v = '0;
    int n = dim_of(s);
    for (int k = 0; k < 8; k++)
      if (r < n && sg*8 + k < n) v[k*16 +: 16] = model[r][sg*8 + k];
    return v;
  endfunction

  task automatic compare();
    n_checks++;
    if (rd_data !== expect_q) begin
      n_errors++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, expect_q);
    end
  endtask

  // Called at a falling edge: drive, update model, clock once, compare.
  task automatic cyc(input logic [1:0] s, input logic we, input int c, input int ws,
                     input logic [127:0] d, input logic re, input int r, input int rs);
    int n = dim_of(s);
    size_sel = s; wr_en = we; wr_col = 5'(c); wr_seg = 2'(ws); wr_data = d;
    rd_en = re; rd_row = 5'(r); rd_seg = 2'(rs);
    if (re) expect_q = model_row(s, r, rs);      // read sees pre-write state
    if (we)
      for (int k = 0; k < 8; k++)
        if (c < n && ws*8 + k < n) model[ws*8 + k][c] = d[k*16 +: 16];
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) model[i][j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: zero after reset, still zero while idle
    tag = "R1";
    @(negedge clk); compare();
    for (int i = 0; i < 3; i++) cyc(2'd3, 1'b0, 0, 0, '0, 1'b0, 0, 0);

    // R2: fill the whole 32x32 array column by column
    tag = "R2";
    for (int c = 0; c < 32; c++)
      for (int s = 0; s < 4; s++) cyc(2'd3, 1'b1, c, s, rnd128(), 1'b0, 0, 0);

    // R3: read every row segment back at full size
    tag = "R3";
    for (int r = 0; r < 32; r++)
      for (int s = 0; s < 4; s++) cyc(2'd3, 1'b0, 0, 0, '0, 1'b1, r, s);

    // R4: same-element write and read in one cycle, then reread
    tag = "R4";
    cyc(2'd3, 1'b1, 5, 0, rnd128(), 1'b1, 3, 0);
    cyc(2'd3, 1'b0, 0, 0, '0, 1'b1, 3, 0);
    cyc(2'd2, 1'b1, 9, 1, rnd128(), 1'b1, 12, 1);
    cyc(2'd2, 1'b0, 0, 0, '0, 1'b1, 12, 1);

    // R5: output held while rd_en is low, even with writes
    tag = "R5";
    cyc(2'd3, 1'b0, 0, 0, '0, 1'b1, 7, 2);
    for (int i = 0; i < 4; i++) cyc(2'd3, 1'b1, 16 + i, 0, rnd128(), 1'b0, 0, 0);

    // R6: 4x4 block, upper write lanes ignored, upper read lanes zero
    tag = "R6";
    for (int c = 0; c < 4; c++) cyc(2'd0, 1'b1, c, 0, rnd128(), 1'b0, 0, 0);
    for (int r = 0; r < 4; r++) cyc(2'd0, 1'b0, 0, 0, '0, 1'b1, r, 0);
    for (int r = 4; r < 8; r++) cyc(2'd3, 1'b0, 0, 0, '0, 1'b1, r, 0);

    // R7: out-of-range writes dropped, out-of-range reads zero
    tag = "R7";
    cyc(2'd1, 1'b1, 12, 0, rnd128(), 1'b0, 0, 0);
    cyc(2'd1, 1'b1, 2, 1, rnd128(), 1'b0, 0, 0);
    cyc(2'd1, 1'b0, 0, 0, '0, 1'b1, 9, 0);
    cyc(2'd1, 1'b0, 0, 0, '0, 1'b1, 2, 1);
    cyc(2'd3, 1'b0, 0, 0, '0, 1'b1, 0, 1);
    cyc(2'd3, 1'b0, 0, 0, '0, 1'b1, 9, 0);

    // R8: back-to-back concurrent column writes and row reads, 8x8
    tag = "R8";
    for (int i = 0; i < 8; i++) cyc(2'd1, 1'b1, i, 0, rnd128(), 1'b1, 7 - i, 0);
    for (int r = 0; r < 8; r++) cyc(2'd1, 1'b0, 0, 0, '0, 1'b1, r, 0);

    // R3: random mix of sizes, indices and concurrent traffic
    tag = "R3";
    for (int i = 0; i < 3000; i++)
      cyc(2'($urandom), 1'($urandom), int'($urandom % 32), int'($urandom % 4),
          rnd128(), 1'($urandom), int'($urandom % 32), int'($urandom % 4));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule